// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

This block collects level-style interrupt requests from up to 32 sources and presents them to a processor as two independent request lines: a normal-priority line and a fast line. Each source first passes through a shared conditioning stage. That stage can invert the input and can capture a rising edge in a latch that holds until software acknowledges it. Both banks then see the same conditioned sources. Each bank applies its own enable mask and its own priority threshold, and each bank nominates one winning source.

Software reaches everything through a small 32-bit register bus with separate read and write strobes. Read data is combinational from the address. A read of a bank's acknowledge register has a side effect: it returns the winning source number, and at the clock edge it clears that source's sticky latch. An interrupt handler keeps looping while the bank's status reads nonzero. In each pass it takes the current source number, services that source, and acknowledges it.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, both enable masks, the polarity word, the sticky word and every source priority read 0. Both thresholds read 0xF. Both request lines are low.
- R2: Writing to a bank's enable-set register (bank offset 0x08) ORs the written ones into that bank's mask. Writing to its enable-clear register (offset 0x0C) removes the written ones from the mask. Zero bits in either write leave the mask unchanged. Reading offset 0x08 returns the mask.
- R3: The polarity word at 0x200 conditions each source. A 1 bit passes the input unchanged and a 0 bit inverts it. Raw status (bank offset 0x04) shows the conditioned sources before masking, and it reads the same in both banks.
- R4: A bank's status (offset 0x00) equals raw status AND the bank mask AND the set of sources whose priority is less than or equal to that bank's threshold. The bank's request line is high exactly while its status is nonzero.
- R5: The current register (offset 0x20) returns the pending source with the numerically lowest priority. A tie goes to the lowest source number. It returns 0 when status is zero.
- R6: The two banks are independent. The normal bank is at 0x000 and the fast bank at 0x100. A mask or threshold written in one bank has no effect on the other bank.
- R7: When a source's bit in the sticky word at 0x204 is 1, a rising edge of its conditioned level sets a latch, and raw status shows the latch, which stays set after the input falls. When the bit is 0, raw status follows the conditioned level.
- R8: Reading a bank's acknowledge register (offset 0x2C) returns the same value as its current register. When status is nonzero, the read also clears the sticky latch of that source. A non-sticky source is unaffected.
- R9: Each source n has a 4-bit priority at 0x300 + 4*n, which is writable and reads back. The threshold sits at bank offset 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; acknowledge side effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_in | input | 32 | Interrupt source levels |
| irq_out | output | 1 | Normal-bank request line |
| fiq_out | output | 1 | Fast-bank request line |

## Verification
The polarity stage is driven with several source words against several polarity words. A fault in either the inversion sense or the bit order shows up in the raw readback.

The arbitration is swept over all sixteen threshold values, with every source pending and the priorities set by a linear formula that gives each value to two sources. This separates the threshold comparison (less-than versus less-or-equal), the choice of the lowest priority value, and the tie-break by lowest index.

Giving the fast bank a sparse mask during the same sweep exposes any coupling between the banks. A pulsed sticky source and a held level source, each acknowledged, show that the latch holds and that only the reported source is cleared.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // bank-relative register offsets
  localparam logic [7:0] OFF_STAT  = 8'h00;
  localparam logic [7:0] OFF_RAW   = 8'h04;
  localparam logic [7:0] OFF_ENSET = 8'h08;
  localparam logic [7:0] OFF_ENCLR = 8'h0C;
  localparam logic [7:0] OFF_CUR   = 8'h20;
  localparam logic [7:0] OFF_THR   = 8'h28;
  localparam logic [7:0] OFF_ACK   = 8'h2C;

  localparam logic [3:0] REG_SHARED = 4'h2;
  localparam logic [3:0] REG_PRIO   = 4'h3;
  localparam logic [7:0] OFF_POL    = 8'h00;
  localparam logic [7:0] OFF_STKY   = 8'h04;

  localparam int PRW = 4;
  localparam logic [PRW-1:0] THR_OPEN = '1;

  typedef enum logic {BANK_NORM = 1'b0, BANK_FAST = 1'b1} bank_e;

  // a source passes the bank filter when its priority is not above the threshold
  function automatic logic prio_passes(input logic [PRW-1:0] p, input logic [PRW-1:0] thr);
    return p <= thr;
  endfunction
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] sticky,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] latch,
  output logic [NSRC-1:0] rise
);
  logic [NSRC-1:0] level;
  logic [NSRC-1:0] prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign level[i] = pol[i] ? src_in[i] : ~src_in[i];
    assign rise[i]  = level[i] & ~prev_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        latch[i]  <= 1'b0;
      end else begin
        prev_q[i] <= level[i];
        if (!sticky[i])   latch[i] <= 1'b0;
        else if (rise[i]) latch[i] <= 1'b1;
        else if (clr[i])  latch[i] <= 1'b0;
      end
    end

    assign raw[i] = sticky[i] ? latch[i] : level[i];
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int IW   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           raw,
  input  logic [NSRC-1:0][PRW-1:0]  prio,
  input  logic                      en_set_we,
  input  logic                      en_clr_we,
  input  logic                      thr_we,
  input  logic [31:0]               wdata,
  output logic [NSRC-1:0]           mask,
  output logic [PRW-1:0]            thr,
  output logic [NSRC-1:0]           status,
  output logic [IW-1:0]             cur,
  output logic                      any
);
  logic [NSRC-1:0] pass;

  function automatic logic [IW-1:0] pick_winner(input logic [NSRC-1:0] st,
                                                input logic [NSRC-1:0][PRW-1:0] pr);
    logic [PRW:0]  best;
    logic [IW-1:0] idx;
    best = {1'b1, {PRW{1'b0}}};
    idx  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (st[i] && ({1'b0, pr[i]} < best)) begin
        best = {1'b0, pr[i]};
        idx  = IW'(i);
      end
    end
    return idx;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      thr  <= THR_OPEN;
    end else begin
      if (en_set_we)      mask <= mask | wdata[NSRC-1:0];
      else if (en_clr_we) mask <= mask & ~wdata[NSRC-1:0];
      if (thr_we)         thr  <= wdata[PRW-1:0];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_pass
    assign pass[i] = prio_passes(prio[i], thr);
  end

  assign status = raw & mask & pass;
  assign any    = |status;
  assign cur    = pick_winner(status, prio);
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out,
  output logic            fiq_out
);
  localparam int IW     = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int NBANK  = 2;

  logic [3:0]                region;
  logic [7:0]                off;
  logic [NSRC-1:0]           pol_q, stky_q;
  logic [NSRC-1:0][PRW-1:0]  prio_q;
  logic [NSRC-1:0]           raw_w, latch_w, rise_w, clr_w;

  logic [NSRC-1:0]  mask_a [NBANK];
  logic [NSRC-1:0]  stat_a [NBANK];
  logic [PRW-1:0]   thr_a  [NBANK];
  logic [IW-1:0]    cur_a  [NBANK];
  logic             any_a  [NBANK];
  logic             hit_a  [NBANK];
  logic             ack_a  [NBANK];
  logic             set_a  [NBANK];
  logic             dis_a  [NBANK];
  logic [NSRC-1:0]  clr_a  [NBANK];

  assign region = bus_addr[11:8];
  assign off    = bus_addr[7:0];

  // shared per-source configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= '0;
      stky_q <= '0;
    end else if (bus_wr && region == REG_SHARED) begin
      if (off == OFF_POL)  pol_q  <= bus_wdata[NSRC-1:0];
      if (off == OFF_STKY) stky_q <= bus_wdata[NSRC-1:0];
    end
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n) prio_q[n] <= '0;
      else if (bus_wr && region == REG_PRIO && off == 8'(4 * n))
        prio_q[n] <= bus_wdata[PRW-1:0];
    end
  end

  intc_src_cond #(.NSRC(NSRC)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in (src_in),
    .pol    (pol_q),
    .sticky (stky_q),
    .clr    (clr_w),
    .raw    (raw_w),
    .latch  (latch_w),
    .rise   (rise_w)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign hit_a[b] = (region == 4'(b));
    assign set_a[b] = bus_wr && hit_a[b] && off == OFF_ENSET;
    assign dis_a[b] = bus_wr && hit_a[b] && off == OFF_ENCLR;
    assign ack_a[b] = bus_rd && hit_a[b] && off == OFF_ACK && any_a[b];
    assign clr_a[b] = ack_a[b] ? (NSRC'(1) << cur_a[b]) : '0;

    intc_bank #(.NSRC(NSRC), .IW(IW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw       (raw_w),
      .prio      (prio_q),
      .en_set_we (set_a[b]),
      .en_clr_we (dis_a[b]),
      .thr_we    (bus_wr && hit_a[b] && off == OFF_THR),
      .wdata     (bus_wdata),
      .mask      (mask_a[b]),
      .thr       (thr_a[b]),
      .status    (stat_a[b]),
      .cur       (cur_a[b]),
      .any       (any_a[b])
    );
  end

  assign clr_w = clr_a[BANK_NORM] | clr_a[BANK_FAST];

  // named views for the checker
  logic [NSRC-1:0] irq_mask_w, irq_stat_w, fiq_mask_w, fiq_stat_w;
  logic [IW-1:0]   irq_cur_w, fiq_cur_w;
  logic            irq_set_w, irq_dis_w;
  assign irq_mask_w = mask_a[BANK_NORM];
  assign irq_stat_w = stat_a[BANK_NORM];
  assign irq_cur_w  = cur_a[BANK_NORM];
  assign fiq_mask_w = mask_a[BANK_FAST];
  assign fiq_stat_w = stat_a[BANK_FAST];
  assign fiq_cur_w  = cur_a[BANK_FAST];
  assign irq_set_w  = set_a[BANK_NORM];
  assign irq_dis_w  = dis_a[BANK_NORM];

  assign irq_out = any_a[BANK_NORM];
  assign fiq_out = any_a[BANK_FAST];

  always_comb begin
    bus_rdata = '0;
    if (region == 4'h0 || region == 4'h1) begin
      case (off)
        OFF_STAT:  bus_rdata = 32'(stat_a[region[0]]);
        OFF_RAW:   bus_rdata = 32'(raw_w);
        OFF_ENSET: bus_rdata = 32'(mask_a[region[0]]);
        OFF_CUR,
        OFF_ACK:   bus_rdata = 32'(cur_a[region[0]]);
        OFF_THR:   bus_rdata = 32'(thr_a[region[0]]);
        default:   bus_rdata = '0;
      endcase
    end else if (region == REG_SHARED) begin
      if (off == OFF_POL)  bus_rdata = 32'(pol_q);
      if (off == OFF_STKY) bus_rdata = 32'(stky_q);
    end else if (region == REG_PRIO) begin
      for (int n = 0; n < NSRC; n++)
        if (off == 8'(4 * n)) bus_rdata = 32'(prio_q[n]);
    end
  end
endmodule

// File: rtl/intc_dual_bank_chk.sv
module intc_dual_bank_chk #(
  parameter int NSRC = 32,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     bus_wdata,
  input logic            irq_out,
  input logic            fiq_out,
  input logic            irq_set,
  input logic            irq_dis,
  input logic [NSRC-1:0] irq_mask,
  input logic [NSRC-1:0] irq_stat,
  input logic [IW-1:0]   irq_cur,
  input logic [NSRC-1:0] fiq_mask,
  input logic [NSRC-1:0] fiq_stat,
  input logic [IW-1:0]   fiq_cur,
  input logic [NSRC-1:0] raw,
  input logic [NSRC-1:0] sticky,
  input logic [NSRC-1:0] latch,
  input logic [NSRC-1:0] rise,
  input logic [NSRC-1:0] clr
);
  p_stat_within_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_stat & ~(irq_mask & raw)) == '0) && ((fiq_stat & ~(fiq_mask & raw)) == '0));

  p_irq_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_stat[irq_cur]);

  p_fiq_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> fiq_stat[fiq_cur]);

  p_idle_current_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out |-> irq_cur == '0) and (!fiq_out |-> fiq_cur == '0));

  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> ((irq_mask & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  p_enable_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dis |=> ((irq_mask & $past(bus_wdata[NSRC-1:0])) == '0));

  p_edge_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & sticky) != '0) |=> ((latch & $past(rise & sticky)) == $past(rise & sticky)));

  p_ack_clears_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~rise) != '0) |=> ((latch & $past(clr & ~rise)) == '0));

  p_single_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr) || $countones(clr) == 2);
endmodule

bind intc_dual_bank intc_dual_bank_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wdata (bus_wdata),
  .irq_out   (irq_out),
  .fiq_out   (fiq_out),
  .irq_set   (irq_set_w),
  .irq_dis   (irq_dis_w),
  .irq_mask  (irq_mask_w),
  .irq_stat  (irq_stat_w),
  .irq_cur   (irq_cur_w),
  .fiq_mask  (fiq_mask_w),
  .fiq_stat  (fiq_stat_w),
  .fiq_cur   (fiq_cur_w),
  .raw       (raw_w),
  .sticky    (stky_q),
  .latch     (latch_w),
  .rise      (rise_w),
  .clr       (clr_w)
);

// File: tb/test_intc_dual_bank.sv
module test_intc_dual_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        irq_out, fiq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_dual_bank i_intc_dual_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [3:0] pv(input int n);
    return 4'((n * 5 + 3) % 16);
  endfunction

  function automatic logic [31:0] winner(input logic [31:0] st);
    int best = 16;
    int idx = 0;
    for (int n = 0; n < 32; n++)
      if (st[n] && int'(pv(n)) < best) begin best = int'(pv(n)); idx = n; end
    return 32'(idx);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, mexp, pass, est;
    logic [31:0] pols [4] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h1234_5678};
    logic [31:0] srcs [3] = '{32'h0, 32'hFFFF_0000, 32'h5A5A_5A5A};
    logic [31:0] fmask;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h008, d); check("R1 irq mask", d, 0);
    rd(12'h108, d); check("R1 fiq mask", d, 0);
    rd(12'h028, d); check("R1 irq thr", d, 32'hF);
    rd(12'h128, d); check("R1 fiq thr", d, 32'hF);
    rd(12'h200, d); check("R1 polarity", d, 0);
    rd(12'h204, d); check("R1 sticky", d, 0);
    rd(12'h31C, d); check("R1 prio7", d, 0);
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 fiq_out", 32'(fiq_out), 0);

    // R3 polarity sweep
    foreach (pols[p]) begin
      wr(12'h200, pols[p]);
      foreach (srcs[s]) begin
        @(negedge clk) src_in = srcs[s];
        rd(12'h004, d); check("R3 raw irq bank", d, ~(srcs[s] ^ pols[p]));
        rd(12'h104, d); check("R3 raw fiq bank", d, ~(srcs[s] ^ pols[p]));
      end
    end

    // R2 / R6 enable set and clear
    mexp = 0;
    wr(12'h008, 32'h0000_00F0); mexp |= 32'h0000_00F0;
    rd(12'h008, d); check("R2 set", d, mexp);
    wr(12'h008, 32'h0000_0F00); mexp |= 32'h0000_0F00;
    rd(12'h008, d); check("R2 set accumulates", d, mexp);
    wr(12'h00C, 32'h0000_0030); mexp &= ~32'h0000_0030;
    rd(12'h008, d); check("R2 clear", d, mexp);
    wr(12'h00C, 32'h0);
    rd(12'h008, d); check("R2 zero clear no effect", d, mexp);
    wr(12'h008, 32'h0);
    rd(12'h008, d); check("R2 zero set no effect", d, mexp);
    rd(12'h108, d); check("R6 fiq mask untouched", d, 0);

    // R9 priorities
    for (int n = 0; n < 32; n++) wr(12'(12'h300 + 4 * n), 32'(pv(n)) | 32'hFFFF_FFF0);
    rd(12'h300, d); check("R9 prio0", d, 32'(pv(0)));
    rd(12'h324, d); check("R9 prio9", d, 32'(pv(9)));
    rd(12'h37C, d); check("R9 prio31", d, 32'(pv(31)));

    // R4 R5 R6 threshold sweep with all sources pending
    wr(12'h200, 32'hFFFF_FFFF);
    @(negedge clk) src_in = 32'hFFFF_FFFF;
    wr(12'h008, 32'hFFFF_FFFF);
    fmask = 32'h0F0F_0F0F;
    wr(12'h108, fmask);
    for (int t = 0; t < 16; t++) begin
      wr(12'h028, 32'(t));
      wr(12'h128, 32'(15 - t));
      pass = 0;
      for (int n = 0; n < 32; n++) pass[n] = (int'(pv(n)) <= t);
      rd(12'h000, d); check("R4 irq status", d, pass);
      rd(12'h020, d); check("R5 irq current", d, winner(pass));
      check("R4 irq_out", 32'(irq_out), 32'(pass != 0));
      est = 0;
      for (int n = 0; n < 32; n++) est[n] = fmask[n] && (int'(pv(n)) <= 15 - t);
      rd(12'h100, d); check("R6 fiq status", d, est);
      rd(12'h120, d); check("R6 fiq current", d, winner(est));
      check("R4 fiq_out", 32'(fiq_out), 32'(est != 0));
    end

    // R5 with a sparse source word
    wr(12'h028, 32'hF);
    @(negedge clk) src_in = 32'h8421_1248;
    rd(12'h000, d); check("R4 sparse status", d, 32'h8421_1248);
    rd(12'h020, d); check("R5 sparse current", d, winner(32'h8421_1248));

    // R4 / R5 empty mask
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h020, d); check("R5 idle current", d, 0);
    check("R4 idle irq_out", 32'(irq_out), 0);

    // R7 / R8 sticky capture and acknowledge
    @(negedge clk) src_in = 32'h0;
    wr(12'h204, 32'h0000_0200);
    wr(12'h008, 32'h0000_0600);
    @(negedge clk) src_in = 32'h0000_0200;
    repeat (2) @(negedge clk);
    src_in = 32'h0;
    repeat (2) @(negedge clk);
    rd(12'h004, d); check("R7 sticky held, level follows", d & 32'h600, 32'h200);
    check("R7 irq_out from latch", 32'(irq_out), 1);
    rd(12'h02C, d); check("R8 ack returns source", d, 9);
    rd(12'h004, d); check("R8 latch cleared", d & 32'h200, 0);
    check("R8 irq_out after ack", 32'(irq_out), 0);

    // R8 level source unaffected by ack
    wr(12'h008, 32'h0000_0008);
    @(negedge clk) src_in = 32'h0000_0008;
    rd(12'h02C, d); check("R8 ack level source", d, 3);
    rd(12'h004, d); check("R8 level source stays", d & 32'h8, 32'h8);
    check("R8 irq_out still high", 32'(irq_out), 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule